// File: doc/BRIEF.md
# Variable Character Height Line Mapper

This block stretches a fixed font cell that is 10 dots wide and 16 rows tall to a programmable character height of 16 to 63 display lines. For every display line inside a character row it gives the index of the font row to fetch. Extra lines are filled by repeating some font rows. The repeats are spread evenly over the cell by an error accumulator, so the block does not need integer scaling.

A scan-timing controller pulses `line_step_i` once per display line. The block keeps the current line position and presents three outputs: the font row for that line, a strobe on the last line of the character row, and a flag that reports an unusable height setting. A height below 16 is treated as 16. The step that leaves the last line starts the next character row at font row 0.

Top module: `osd_char_height_map`

## Requirements
- R1: After an asynchronous reset (`rst_ni` low), `font_row_o` is 0 and `row_end_o` is 0.
- R2: With an effective height H held constant, the line with index l (0 to H-1, counted from the start of the character row) shows `font_row_o` = floor(l*16/H).
- R3: `row_end_o` is 1 on line H-1 only, so each character row lasts exactly H steps.
- R4: Within a character row, each step leaves `font_row_o` unchanged or raises it by exactly 1, and every font row 0 to 15 appears on at least one line.
- R5: A `height_i` value below 16 behaves exactly like 16, and `height_bad_o` is 1 while `height_i` < 16. For values of 16 or more, `height_bad_o` is 0.
- R6: While `line_step_i` is 0, `font_row_o` and `row_end_o` do not change.
- R7: A step taken while `row_end_o` is 1 returns `font_row_o` to 0, and the next character row repeats the same line sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| height_i | input | 6 | Programmed character height in lines |
| line_step_i | input | 1 | Advance one display line (one-cycle pulse per line) |
| font_row_o | output | 4 | Font row index for the current line |
| row_end_o | output | 1 | High on the last line of the character row |
| height_bad_o | output | 1 | Height setting is below 16 |

## Verification
If the accumulator holds a wrong remainder, a repeated row lands on the wrong line. This shows up as a `font_row_o` mismatch on the first line affected, within one step. It can also show as a skipped row, which breaks the step-of-at-most-one rule at once. If the line counter is off, `row_end_o` comes early or late. The wrap back to row 0 then lands on the wrong step, so the error is visible no later than the end of that character row. The bench compares every line for several heights, including the two limits and a clamped value, so any of these faults surfaces within one character row.

// File: rtl/osd_vch_pkg.sv
package osd_vch_pkg;
  localparam int unsigned FONT_ROWS_DEF = 16;
  localparam int unsigned FONT_COLS     = 10;
  localparam int unsigned HEIGHT_W_DEF  = 6;
endpackage

// File: rtl/vch_height_clamp.sv
module vch_height_clamp #(
  parameter int unsigned HEIGHT_W = 6,
  parameter int unsigned MIN_H    = 16
) (
  input  logic [HEIGHT_W-1:0] height_i,
  output logic [HEIGHT_W-1:0] height_eff_o,
  output logic                bad_o
);
  localparam logic [HEIGHT_W-1:0] MIN_V = HEIGHT_W'(MIN_H);

  always_comb begin
    bad_o        = (height_i < MIN_V);
    height_eff_o = bad_o ? MIN_V : height_i;
  end
endmodule

// File: rtl/vch_line_ctr.sv
module vch_line_ctr #(
  parameter int unsigned HEIGHT_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic [HEIGHT_W-1:0] height_eff_i,
  output logic                last_o
);
  logic [HEIGHT_W-1:0] line_q;

  // >= keeps a mid-row height reduction from running past the end
  assign last_o = (line_q >= height_eff_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     line_q <= '0;
    else if (step_i) line_q <= last_o ? '0 : line_q + 1'b1;
  end
endmodule

// File: rtl/vch_row_accum.sv
module vch_row_accum #(
  parameter int unsigned HEIGHT_W  = 6,
  parameter int unsigned FONT_ROWS = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         step_i,
  input  logic                         restart_i,
  input  logic [HEIGHT_W-1:0]          height_eff_i,
  output logic [$clog2(FONT_ROWS)-1:0] row_o
);
  localparam int unsigned ROW_W = $clog2(FONT_ROWS);
  localparam int unsigned ACC_W = HEIGHT_W + 1;
  localparam logic [ACC_W-1:0] INC     = ACC_W'(FONT_ROWS);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(FONT_ROWS - 1);

  logic [ACC_W-1:0] acc_q, acc_sum, acc_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             carry;

  always_comb begin
    acc_sum = acc_q + INC;
    carry   = (acc_sum >= {1'b0, height_eff_i});
    acc_d   = carry ? acc_sum - {1'b0, height_eff_i} : acc_sum;
    row_d   = (carry && row_q != ROW_MAX) ? row_q + 1'b1 : row_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      row_q <= '0;
    end else if (step_i) begin
      if (restart_i) begin
        acc_q <= '0;
        row_q <= '0;
      end else begin
        acc_q <= acc_d;
        row_q <= row_d;
      end
    end
  end

  assign row_o = row_q;
endmodule

// File: rtl/osd_char_height_map.sv
module osd_char_height_map
  import osd_vch_pkg::*;
#(
  parameter int unsigned HEIGHT_W  = HEIGHT_W_DEF,
  parameter int unsigned FONT_ROWS = FONT_ROWS_DEF
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [HEIGHT_W-1:0]          height_i,
  input  logic                         line_step_i,
  output logic [$clog2(FONT_ROWS)-1:0] font_row_o,
  output logic                         row_end_o,
  output logic                         height_bad_o
);
  logic [HEIGHT_W-1:0] height_eff;
  logic                last_line;

  vch_height_clamp #(.HEIGHT_W(HEIGHT_W), .MIN_H(FONT_ROWS)) u_clamp (
    .height_i    (height_i),
    .height_eff_o(height_eff),
    .bad_o       (height_bad_o)
  );

  vch_line_ctr #(.HEIGHT_W(HEIGHT_W)) u_line (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (line_step_i),
    .height_eff_i(height_eff),
    .last_o      (last_line)
  );

  vch_row_accum #(.HEIGHT_W(HEIGHT_W), .FONT_ROWS(FONT_ROWS)) u_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (line_step_i),
    .restart_i   (last_line),
    .height_eff_i(height_eff),
    .row_o       (font_row_o)
  );

  assign row_end_o = last_line;
endmodule

// File: rtl/osd_char_height_map_chk.sv
module osd_char_height_map_chk #(
  parameter int unsigned HEIGHT_W  = 6,
  parameter int unsigned FONT_ROWS = 16
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [HEIGHT_W-1:0]          height_i,
  input logic                         line_step_i,
  input logic [$clog2(FONT_ROWS)-1:0] font_row_o,
  input logic                         row_end_o,
  input logic                         height_bad_o
);
  localparam logic [HEIGHT_W-1:0] MIN_V = HEIGHT_W'(FONT_ROWS);

  a_r4_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_step_i && !row_end_o) |=>
      (font_row_o == $past(font_row_o) || font_row_o == $past(font_row_o) + 1'b1));

  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_step_i && row_end_o) |=> (font_row_o == '0));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_step_i && $stable(height_i)) |=> ($stable(font_row_o) && $stable(row_end_o)));

  a_r5_bad_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    height_bad_o == (height_i < MIN_V));
endmodule

bind osd_char_height_map osd_char_height_map_chk #(
  .HEIGHT_W(HEIGHT_W), .FONT_ROWS(FONT_ROWS)
) u_chk (.*);

// File: tb/osd_char_height_map_bench.sv
module osd_char_height_map_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] height = 6'd16;
  logic       step = 1'b0;
  logic [3:0] font_row;
  logic       row_end;
  logic       height_bad;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  osd_char_height_map u_osd_char_height_map (
    .clk_i(clk), .rst_ni(rst_n), .height_i(height), .line_step_i(step),
    .font_row_o(font_row), .row_end_o(row_end), .height_bad_o(height_bad)
  );

  // {expected bad flag, height}
  localparam logic [6:0] VEC [9] = '{
    {1'b0, 6'd16}, {1'b0, 6'd17}, {1'b0, 6'd22}, {1'b0, 6'd25}, {1'b0, 6'd34},
    {1'b0, 6'd41}, {1'b0, 6'd63}, {1'b1, 6'd5},  {1'b1, 6'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_line();
    @(negedge clk) step = 1'b1;
    @(negedge clk) step = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 font_row", font_row, 0);
    chk("R1 row_end", row_end, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[v]) begin
      int h;
      int seen;
      height = VEC[v][5:0];
      h = (height < 16) ? 16 : height;
      @(negedge clk);
      chk("R5 bad flag", height_bad, VEC[v][6]);
      for (int pass = 0; pass < 2; pass++) begin
        seen = 0;
        for (int l = 0; l < h; l++) begin
          chk("R2 font_row", font_row, (l * 16) / h);
          chk("R3 row_end", row_end, (l == h - 1) ? 1 : 0);
          seen |= (1 << font_row);
          step_line();
        end
        chk("R4 all rows seen", seen, 32'hFFFF);
        chk("R7 wrap to row 0", font_row, 0);
      end
    end

    // R6: hold with no step, mid row
    height = 6'd25;
    repeat (7) step_line();
    chk("R6 pre hold row", font_row, (7 * 16) / 25);
    repeat (6) @(negedge clk);
    chk("R6 hold row", font_row, (7 * 16) / 25);
    chk("R6 hold row_end", row_end, 0);

    // R1: async reset mid row
    #3 rst_n = 1'b0;
    #1;
    chk("R1 async font_row", font_row, 0);
    chk("R1 async row_end", row_end, 0);
    @(negedge clk) rst_n = 1'b1;
    for (int l = 0; l < 25; l++) step_line();
    chk("R3 after reset wrap", font_row, 0);
    chk("R5 flag clear at 25", height_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule